// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner among a small set of requesters, four by default, in every clock cycle. Its grant is a one-hot vector that follows the request vector combinationally, in the same cycle. The winner is always the active requester that was served longest ago. Hardware that shares one resource between a few clients uses it to hand out access one cycle at a time.

Relative priority is kept as one precedence bit per unordered pair of requesters. Only the pairs with the lower index first are stored; the reverse relation is the complement. After each cycle that issues a grant, the granted requester loses precedence against every other requester. The order of all the others is left as it was. Cycles without a grant leave the state untouched. On reset, a lower index takes precedence over every higher index. The reset input is asserted asynchronously and released in step with the clock.

Top module: `lrs_matrix_arb`

## Requirements
- R1: After reset, and before any grant has been issued, the lowest-indexed active requester wins (bit i of `gnt_o` belongs to `req_i` bit i).
- R2: `gnt_o` never has more than one bit set.
- R3: When any bit of `req_i` is set, exactly one bit of `gnt_o` is set in the same cycle; when `req_i` is zero, `gnt_o` is zero.
- R4: A bit of `gnt_o` is set only when the matching bit of `req_i` is set.
- R5: A requester granted in one cycle has lower precedence than every other requester from the next cycle on. If it requests again alongside any other requester, it loses.
- R6: A cycle in which no grant is issued leaves the precedence order unchanged.
- R7: Among requesters that keep requesting, each one waits through at most NUM_REQ-1 grants to others before it is served.
- R8: The winner is the active requester granted least recently. Requesters never granted since reset rank by index, lowest first, and all of them rank ahead of any requester granted since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Reset, active low, asynchronous assert, synchronous release |
| req_i | input | NUM_REQ | One request bit per requester |
| gnt_o | output | NUM_REQ | One-hot grant, zero when nothing requests |

## Verification
A corrupted precedence bit does not show at the ports until the two requesters of that pair compete while no third requester outranks both. From then on, the wrong one of the two is granted in that same cycle. A missed update after a grant shows up as the same requester winning twice in a row against a rival. A spurious update during idle cycles reorders the first grants after the idle period. The bench therefore keeps an independent service-order list. It compares every cycle's grant against that list under random request patterns, long all-request runs and idle gaps, so a divergence is caught within the cycle of the first contended arbitration it affects.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;

  // Position of pair (lo, hi), lo < hi, in a packed upper-triangle vector.
  function automatic int pair_idx(input int lo, input int hi, input int n);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

  function automatic int pair_count(input int n);
    return n * (n - 1) / 2;
  endfunction

endpackage

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;
endmodule

// File: rtl/lrs_prec_state.sv
module lrs_prec_state #(
  parameter int NUM_REQ = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_REQ-1:0]           gnt_i,
  output logic [lrs_arb_pkg::pair_count(NUM_REQ)-1:0] state_o,
  output logic [NUM_REQ*NUM_REQ-1:0]   prec_o
);
  import lrs_arb_pkg::*;

  localparam int NPAIR = pair_count(NUM_REQ);

  logic [NPAIR-1:0] tri_d;
  logic [NPAIR-1:0] tri_q;
  logic             upd_en;

  assign upd_en = |gnt_i;

  // Next state: column grant sets, row grant clears.
  always_comb begin
    tri_d = tri_q;
    for (int lo = 0; lo < NUM_REQ; lo++) begin
      for (int hi = lo + 1; hi < NUM_REQ; hi++) begin
        if (gnt_i[hi]) begin
          tri_d[pair_idx(lo, hi, NUM_REQ)] = 1'b1;
        end else if (gnt_i[lo]) begin
          tri_d[pair_idx(lo, hi, NUM_REQ)] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tri_q <= '1;
    end else if (upd_en) begin
      tri_q <= tri_d;
    end
  end

  assign state_o = tri_q;

  // Expand to full matrix: prec_o[a*N+b] = 1 when a beats b.
  for (genvar a = 0; a < NUM_REQ; a++) begin : g_row
    for (genvar b = 0; b < NUM_REQ; b++) begin : g_col
      if (a < b) begin : g_upper
        assign prec_o[a*NUM_REQ+b] = tri_q[pair_idx(a, b, NUM_REQ)];
      end else if (a > b) begin : g_lower
        assign prec_o[a*NUM_REQ+b] = ~tri_q[pair_idx(b, a, NUM_REQ)];
      end else begin : g_diag
        assign prec_o[a*NUM_REQ+b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lrs_grant_pick.sv
module lrs_grant_pick #(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0]         req_i,
  input  logic [NUM_REQ*NUM_REQ-1:0] prec_i,
  output logic [NUM_REQ-1:0]         gnt_o
);
  for (genvar c = 0; c < NUM_REQ; c++) begin : g_cand
    logic beaten;
    always_comb begin
      beaten = 1'b0;
      for (int k = 0; k < NUM_REQ; k++) begin
        if (k != c && req_i[k] && prec_i[k*NUM_REQ+c]) begin
          beaten = 1'b1;
        end
      end
    end
    assign gnt_o[c] = req_i[c] & ~beaten;
  end
endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  localparam int NPAIR = lrs_arb_pkg::pair_count(NUM_REQ);

  logic                       rst_sync_n;
  logic [NUM_REQ*NUM_REQ-1:0] prec;
  logic [NPAIR-1:0]           w_state;
  logic [NUM_REQ-1:0]         gnt;

  lrs_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  lrs_prec_state #(.NUM_REQ(NUM_REQ)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .gnt_i   (gnt),
    .state_o (w_state),
    .prec_o  (prec)
  );

  lrs_grant_pick #(.NUM_REQ(NUM_REQ)) u_pick (
    .req_i  (req_i),
    .prec_i (prec),
    .gnt_o  (gnt)
  );

  assign gnt_o = gnt;
endmodule

// File: rtl/lrs_matrix_arb_chk.sv
module lrs_matrix_arb_chk #(
  parameter int NUM_REQ = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_REQ-1:0]         req_i,
  input logic [NUM_REQ-1:0]         gnt_o,
  input logic [lrs_arb_pkg::pair_count(NUM_REQ)-1:0] state_i
);
  localparam int CW = $clog2(NUM_REQ) + 2;

  // R2
  one_grant_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R3
  grant_when_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> ($countones(gnt_o) == 1));

  // R3
  idle_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (gnt_o == '0));

  // R4
  grant_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  // R6
  hold_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> $stable(state_i));

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q <= '0;
      end else if (!req_i[r] || gnt_o[r]) begin
        wait_q <= '0;
      end else if (|gnt_o) begin
        wait_q <= wait_q + 1'b1;
      end
    end

    // R5
    loses_after_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[r] ##1 (req_i[r] && ((req_i & ~(NUM_REQ'(1) << r)) != '0)))
        |-> !gnt_o[r]);

    // R7
    bounded_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q < CW'(NUM_REQ));
  end
endmodule

bind lrs_matrix_arb lrs_matrix_arb_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .req_i   (req_i),
  .gnt_o   (gnt_o),
  .state_i (w_state)
);

// File: tb/lrs_matrix_arb_tb.sv
`timescale 1ns/1ps
module lrs_matrix_arb_tb;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [N-1:0] req_i;
  logic [N-1:0] gnt_o;

  int n_chk  = 0;
  int n_fail = 0;
  int ord[N];      // ord[0] = highest precedence
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lrs_matrix_arb #(.NUM_REQ(N)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .gnt_o  (gnt_o)
  );

  function automatic logic [N-1:0] exp_gnt(input logic [N-1:0] rq);
    for (int p = 0; p < N; p++) begin
      if (rq[ord[p]]) return N'(1) << ord[p];
    end
    return '0;
  endfunction

  function automatic void model_update(input logic [N-1:0] g);
    int pos = -1;
    int who;
    for (int p = 0; p < N; p++) if (g[ord[p]]) pos = p;
    if (pos < 0) return;
    who = ord[pos];
    for (int p = pos; p < N - 1; p++) ord[p] = ord[p+1];
    ord[N-1] = who;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: req=%b gnt got %b expected %b", tag, req_i, got, exp);
    end
  endtask

  // Drive req just after the edge, check before the next edge, update model.
  task automatic cycle(input logic [N-1:0] rq, input string tag);
    logic [N-1:0] e;
    @(posedge clk_i);
    #1 req_i = rq;
    #1;
    e = exp_gnt(rq);
    check(tag, gnt_o, e);
    check("R4", gnt_o & ~rq, '0);
    model_update(e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < N; p++) ord[p] = p;
    req_i  = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);

    // R3: no request, no grant
    cycle(4'b0000, "R3 idle");
    // R1: reset order, lowest index first
    cycle(4'b1010, "R1 reset order");
    // R5: index 1 just won, now loses to 3
    cycle(4'b1010, "R5 demote");
    cycle(4'b1010, "R5 alternate");
    // R8: 0 and 2 never served, rank ahead of 1 and 3
    cycle(4'b1111, "R8 unserved first");
    // R7: continuous requests rotate
    for (int k = 0; k < 3 * N; k++) cycle(4'b1111, "R7 rotation");
    // R6: idle gap does not disturb order
    for (int k = 0; k < 5; k++) cycle(4'b0000, "R6 idle");
    cycle(4'b1111, "R6 order kept");
    cycle(4'b0110, "R6 order kept");
    // R2/R3: single requester repeatedly
    for (int k = 0; k < 4; k++) cycle(4'b0100, "R3 single");
    cycle(4'b0101, "R5 repeat winner loses");
    // Random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] rq;
      rq = N'($urandom);
      if ($urandom_range(7) == 0) rq = '0;
      cycle(rq, "R8 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule